// File: doc/BRIEF.md
# Virtual Function Capability Register Bank

This block holds the configuration-space registers of the single-root virtualization extended capability for one physical function. A 32-bit register port with a word address, write strobe, per-byte lane enables and write data reaches sixteen words of state. Read data is combinational from the address. A second select input, `reg_alt`, reaches the hidden side of words that hold more than one physical register. Through it software can write the other NumVFs copy, a BAR mask, or one of the read-only identity words.

The block drives two values to the rest of the controller. The first is the live control bits. The second is the NumVFs count held in the copy that the ARI-hierarchy control bit selects. The supported-page-size word uses one bit per size: bit n set means pages of 2^(n+12) bytes are supported, so bit 0 stands for 4 KB. Each of the six VF BAR words has a mask of the same width. Bits set in the mask are hidden from reads and protected from normal writes.

Top module: `vfcap_regs`

## Requirements
- R1: After reset, reads give these values: word 0 = 0x29C10010, word 1 = 0x00000006, word 2 = 0, word 3 = 0x01000100, word 4 = 0, word 5 = 0x01000100, word 6 = 0x11720000, word 7 = 0x00000553, word 8 = 0x00000001, and words 9 to 15 = 0. After reset `ctl_bits` and `active_numvfs` are 0.
- R2: The identity words are word 0 (header), word 1 (capabilities), word 3 (VF counts), word 5 (stride/offset), word 6 (VF device ID) and word 7 (supported page sizes). A write to any of them with `reg_alt` low changes nothing. A write with `reg_alt` high updates the enabled byte lanes.
- R3: Word 2 is the control word. Bits [4:0] are writable: bit 0 VF enable, bit 1 migration enable, bit 2 migration interrupt enable, bit 3 VF memory space enable, bit 4 ARI hierarchy. Bits [31:5] read as zero. `ctl_bits` always equals bits [4:0].
- R4: `reg_be[k]` enables `reg_wdata[8k+7:8k]` on every writable field. Word 8 (system page size) is writable in all 32 bits whatever the level of `reg_alt`.
- R5: Word 4 holds two NumVFs copies: copy 0 for non-ARI hierarchies and copy 1 for ARI hierarchies. A read returns the copy selected by control bit 4. In each copy, bits [15:0] are the VF count, bits [23:16] are the dependency link, and bits [31:24] read as zero.
- R6: A write to word 4 with `reg_alt` low updates the selected copy. A write with `reg_alt` high updates the other copy.
- R7: `active_numvfs` carries bits [15:0] of the selected copy. It changes one clock after the edge that writes the selected copy or changes control bit 4. Otherwise it holds its value.
- R8: In the BAR words 9 to 14, bits [3:0] always read as zero and are never written.
- R9: Each BAR word has a 32-bit mask at the same word. A write with `reg_alt` high updates the mask. A read with `reg_alt` high returns the mask.
- R10: BAR bits whose mask bit is set read as zero when `reg_alt` is low. Normal writes do not change them.
- R11: Word 15 (migration-state offset) reads as zero and ignores writes while capability bit 0 (migration capable) is clear. When that bit is set, the word is fully writable and readable.
- R12: Words 16 to 31 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | AW (5) | Word address |
| reg_we | input | 1 | Write strobe |
| reg_be | input | 4 | Byte lane enables |
| reg_wdata | input | 32 | Write data |
| reg_alt | input | 1 | Secondary select for hidden and alternate registers |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ctl_bits | output | CTL_W (5) | Live control bits |
| active_numvfs | output | 16 | NumVFs of the selected copy |

## Verification
The register port is exercised with several kinds of access. Normal writes to read-only words must leave them unchanged, while select-asserted writes with partial lane enables must change only the enabled bytes. NumVFs writes are made with both select levels under both ARI settings; this shows whether writes land in the selected copy or the other one, and whether reads follow the ARI bit. BAR writes with and without masks separate value storage, mask storage and the locked type nibble. Migration-word writes made before and after the capability bit is set, and aliased addresses above word 15, show whether gating and full address decode hold.

// File: rtl/vfcap_regs.sv
module vfcap_regs #(
  parameter int          AW      = 5,
  parameter int          NBAR    = 6,
  parameter int          CTL_W   = 5,
  parameter logic [31:0] HDR_RST = 32'h29C10010,
  parameter logic [31:0] CAP_RST = 32'h00000006,
  parameter logic [31:0] CNT_RST = 32'h01000100,
  parameter logic [31:0] SOS_RST = 32'h01000100,
  parameter logic [31:0] DID_RST = 32'h11720000,
  parameter logic [31:0] PGS_RST = 32'h00000553,
  parameter logic [31:0] SPS_RST = 32'h00000001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    reg_addr,
  input  logic             reg_we,
  input  logic [3:0]       reg_be,
  input  logic [31:0]      reg_wdata,
  input  logic             reg_alt,
  output logic [31:0]      reg_rdata,
  output logic [CTL_W-1:0] ctl_bits,
  output logic [15:0]      active_numvfs
);
  localparam int          ARI_BIT  = 4;
  localparam int          BAR_IDX  = 9;
  localparam logic [31:0] TYPE_LCK = 32'h0000000F;
  localparam logic [31:0] NV_LCK   = 32'hFF000000;
  localparam logic [31:0] CTL_LCK  = ~((32'd1 << CTL_W) - 32'd1);
  localparam logic [AW-1:0] A_HDR = AW'(0);
  localparam logic [AW-1:0] A_CAP = AW'(1);
  localparam logic [AW-1:0] A_CTL = AW'(2);
  localparam logic [AW-1:0] A_CNT = AW'(3);
  localparam logic [AW-1:0] A_NUM = AW'(4);
  localparam logic [AW-1:0] A_SOS = AW'(5);
  localparam logic [AW-1:0] A_DID = AW'(6);
  localparam logic [AW-1:0] A_PGS = AW'(7);
  localparam logic [AW-1:0] A_SPS = AW'(8);
  localparam logic [AW-1:0] A_MIG = AW'(BAR_IDX + NBAR);

  logic [31:0]      hdr_q, caps_q, cnt_q, sos_q, did_q, pgs_q, sps_q, mig_q;
  logic [CTL_W-1:0] ctl_q;
  logic [31:0]      nv_q  [2];
  logic [31:0]      bar_q [NBAR];
  logic [31:0]      msk_q [NBAR];
  logic [15:0]      act_q;
  logic             ari;

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] be, input logic [31:0] lock);
    logic [31:0] m;
    m = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}} & ~lock;
    return (old & ~m) | (d & m);
  endfunction

  assign ari           = ctl_q[ARI_BIT];
  assign ctl_bits      = ctl_q;
  assign active_numvfs = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_q <= HDR_RST;  caps_q <= CAP_RST;  cnt_q <= CNT_RST;  sos_q <= SOS_RST;
      did_q <= DID_RST;  pgs_q  <= PGS_RST;  sps_q <= SPS_RST;  mig_q <= '0;
      ctl_q <= '0;  nv_q[0] <= '0;  nv_q[1] <= '0;  act_q <= '0;
      for (int i = 0; i < NBAR; i++) begin
        bar_q[i] <= '0;
        msk_q[i] <= '0;
      end
    end else begin
      act_q <= nv_q[ari][15:0];
      if (reg_we) begin
        case (reg_addr)
          A_HDR: if (reg_alt) hdr_q  <= merge(hdr_q,  reg_wdata, reg_be, '0);
          A_CAP: if (reg_alt) caps_q <= merge(caps_q, reg_wdata, reg_be, '0);
          A_CTL: ctl_q <= CTL_W'(merge(32'(ctl_q), reg_wdata, reg_be, CTL_LCK));
          A_CNT: if (reg_alt) cnt_q  <= merge(cnt_q,  reg_wdata, reg_be, '0);
          A_NUM: nv_q[ari ^ reg_alt] <= merge(nv_q[ari ^ reg_alt], reg_wdata, reg_be, NV_LCK);
          A_SOS: if (reg_alt) sos_q  <= merge(sos_q,  reg_wdata, reg_be, '0);
          A_DID: if (reg_alt) did_q  <= merge(did_q,  reg_wdata, reg_be, '0);
          A_PGS: if (reg_alt) pgs_q  <= merge(pgs_q,  reg_wdata, reg_be, '0);
          A_SPS: sps_q <= merge(sps_q, reg_wdata, reg_be, '0);
          A_MIG: if (caps_q[0]) mig_q <= merge(mig_q, reg_wdata, reg_be, '0);
          default: ;
        endcase
        for (int i = 0; i < NBAR; i++) begin
          if (reg_addr == AW'(BAR_IDX + i)) begin
            if (reg_alt) msk_q[i] <= merge(msk_q[i], reg_wdata, reg_be, '0);
            else         bar_q[i] <= merge(bar_q[i], reg_wdata, reg_be, msk_q[i] | TYPE_LCK);
          end
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_HDR: reg_rdata = hdr_q;
      A_CAP: reg_rdata = caps_q;
      A_CTL: reg_rdata = 32'(ctl_q);
      A_CNT: reg_rdata = cnt_q;
      A_NUM: reg_rdata = nv_q[ari];
      A_SOS: reg_rdata = sos_q;
      A_DID: reg_rdata = did_q;
      A_PGS: reg_rdata = pgs_q;
      A_SPS: reg_rdata = sps_q;
      A_MIG: reg_rdata = caps_q[0] ? mig_q : '0;
      default: ;
    endcase
    for (int i = 0; i < NBAR; i++) begin
      if (reg_addr == AW'(BAR_IDX + i))
        reg_rdata = reg_alt ? msk_q[i] : (bar_q[i] & ~msk_q[i]);
    end
  end
endmodule

module vfcap_regs_chk #(
  parameter int AW    = 5,
  parameter int CTL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    reg_addr,
  input logic             reg_we,
  input logic             reg_alt,
  input logic [31:0]      reg_rdata,
  input logic [CTL_W-1:0] ctl_bits,
  input logic [15:0]      active_numvfs,
  input logic             mig_cap
);
  a_r3_ctl_mirror: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(2)) |-> (reg_rdata[CTL_W-1:0] == ctl_bits && reg_rdata[31:CTL_W] == '0));

  a_r5_num_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(4)) |-> (reg_rdata[31:24] == 8'h00));

  a_r7_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> ##1 $stable(active_numvfs));

  a_r8_bar_type_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= AW'(9) && reg_addr <= AW'(14) && !reg_alt) |-> (reg_rdata[3:0] == 4'h0));

  a_r11_mig_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(15) && !mig_cap) |-> (reg_rdata == '0));

  a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= AW'(16)) |-> (reg_rdata == '0));
endmodule

bind vfcap_regs vfcap_regs_chk #(.AW(AW), .CTL_W(CTL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we), .reg_alt(reg_alt),
  .reg_rdata(reg_rdata), .ctl_bits(ctl_bits), .active_numvfs(active_numvfs),
  .mig_cap(caps_q[0])
);

// File: tb/sim_vfcap_regs.sv
`timescale 1ns/1ps
module sim_vfcap_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_alt = 1'b0;
  logic [31:0] reg_rdata;
  logic [4:0]  ctl_bits;
  logic [15:0] active_numvfs;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vfcap_regs u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we), .reg_be(reg_be),
    .reg_wdata(reg_wdata), .reg_alt(reg_alt), .reg_rdata(reg_rdata),
    .ctl_bits(ctl_bits), .active_numvfs(active_numvfs)
  );

  // {req[50:43], wr[42], alt[41], addr[40:36], be[35:32], data[31:0]}
  function automatic logic [50:0] V(input int req, input bit wr, input bit alt,
                                    input int a, input logic [3:0] be, input logic [31:0] d);
    return {8'(req), wr, alt, 5'(a), be, d};
  endfunction

  localparam int NV = 63;
  localparam logic [50:0] VEC [NV] = '{
    // R1 reset values
    V(1,0,0,0,4'hF,32'h29C10010), V(1,0,0,1,4'hF,32'h00000006), V(1,0,0,2,4'hF,32'h0),
    V(1,0,0,3,4'hF,32'h01000100), V(1,0,0,4,4'hF,32'h0),        V(1,0,0,5,4'hF,32'h01000100),
    V(1,0,0,6,4'hF,32'h11720000), V(1,0,0,7,4'hF,32'h00000553), V(1,0,0,8,4'hF,32'h00000001),
    V(1,0,0,9,4'hF,32'h0),        V(1,0,0,15,4'hF,32'h0),
    // R2 identity word: normal write ignored, alternate write per lane
    V(2,1,0,6,4'hF,32'hFFFFFFFF), V(2,0,0,6,4'hF,32'h11720000),
    V(2,1,1,6,4'h3,32'hAAAABBBB), V(2,0,0,6,4'hF,32'h1172BBBB),
    // R4 byte lanes on system page size
    V(4,1,0,8,4'h1,32'h12345678), V(4,0,0,8,4'hF,32'h00000078),
    V(4,1,1,8,4'h8,32'hAB000000), V(4,0,0,8,4'hF,32'hAB000078),
    // R3 control word
    V(3,1,0,2,4'hF,32'hFFFFFFFF), V(3,0,0,2,4'hF,32'h0000001F),
    V(3,1,0,2,4'hF,32'h0),        V(3,0,0,2,4'hF,32'h0),
    // R5 R6 NumVFs copies
    V(5,1,0,4,4'hF,32'hFFFF0012), V(5,0,0,4,4'hF,32'h00FF0012),
    V(6,1,1,4,4'hF,32'h00000034), V(6,0,0,4,4'hF,32'h00FF0012),
    V(5,1,0,2,4'hF,32'h00000010), V(5,0,0,4,4'hF,32'h00000034),
    V(6,1,0,4,4'h1,32'h00000056), V(6,0,0,4,4'hF,32'h00000056),
    V(6,1,1,4,4'hF,32'h00000099), V(6,0,0,4,4'hF,32'h00000056),
    V(5,1,0,2,4'hF,32'h0),        V(5,0,0,4,4'hF,32'h00000099),
    // R8 R9 R10 BARs and masks
    V(8,1,0,9,4'hF,32'hFFFFFFFF), V(8,0,0,9,4'hF,32'hFFFFFFF0),
    V(9,1,1,9,4'hF,32'hFFF00000), V(9,0,1,9,4'hF,32'hFFF00000),
    V(10,0,0,9,4'hF,32'h000FFFF0),
    V(10,1,1,10,4'hF,32'hFFFF0000), V(10,1,0,10,4'hF,32'h12345678),
    V(10,0,0,10,4'hF,32'h00005670),
    V(9,1,1,10,4'hF,32'h0),       V(10,0,0,10,4'hF,32'h00005670),
    V(8,1,0,14,4'h4,32'h00AB0000), V(8,0,0,14,4'hF,32'h00AB0000),
    // R11 migration offset gating
    V(11,1,0,15,4'hF,32'hDEADBEEF), V(11,0,0,15,4'hF,32'h0),
    V(11,1,1,1,4'h1,32'h00000007),  V(11,0,0,1,4'hF,32'h00000007),
    V(11,0,0,15,4'hF,32'h0),
    V(11,1,0,15,4'hF,32'hDEADBEEF), V(11,0,0,15,4'hF,32'hDEADBEEF),
    V(11,1,1,1,4'h1,32'h00000006),  V(11,0,0,15,4'hF,32'h0),
    V(11,1,0,15,4'hF,32'h11111111),
    V(11,1,1,1,4'h1,32'h00000007),  V(11,0,0,15,4'hF,32'hDEADBEEF),
    // R12 unmapped words
    V(12,0,0,16,4'hF,32'h0), V(12,0,0,31,4'hF,32'h0),
    V(12,1,0,24,4'hF,32'h0), V(12,0,0,8,4'hF,32'hAB000078)
  };

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input bit alt, input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_alt = alt; reg_be = be; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int req, input bit alt, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a; reg_alt = alt;
    #1;
    check(req, $sformatf("read word %0d alt %0d", a, alt), reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung run expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check(1, "ctl_bits after reset", 32'(ctl_bits), 32'h0);           // R1
    check(1, "active_numvfs after reset", 32'(active_numvfs), 32'h0); // R1

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][42]) wr(VEC[i][41], VEC[i][40:36], VEC[i][35:32], VEC[i][31:0]);
      else            rd(int'(VEC[i][50:43]), VEC[i][41], VEC[i][40:36], VEC[i][31:0]);
    end

    // R7: ARI clear, copy0 = 0x99, copy1 = 0x56
    check(7, "active idle", 32'(active_numvfs), 32'h99);
    wr(1'b0, 5'd4, 4'hF, 32'h00000123);
    check(7, "active one cycle after write", 32'(active_numvfs), 32'h99);
    @(negedge clk);
    check(7, "active two cycles after write", 32'(active_numvfs), 32'h123);
    wr(1'b0, 5'd2, 4'hF, 32'h00000010);
    check(3, "ctl_bits ARI set", 32'(ctl_bits), 32'h10);
    check(7, "active right after ARI flip", 32'(active_numvfs), 32'h123);
    @(negedge clk);
    check(7, "active after ARI flip", 32'(active_numvfs), 32'h56);
    wr(1'b1, 5'd4, 4'hF, 32'h00000777); // R6: goes to copy0, not selected
    @(negedge clk);
    check(7, "active unchanged by other copy", 32'(active_numvfs), 32'h56);
    rd(6, 1'b0, 5'd4, 32'h00000056);
    wr(1'b0, 5'd2, 4'hF, 32'h0);
    @(negedge clk);
    check(7, "active after ARI clear", 32'(active_numvfs), 32'h777);
    check(3, "ctl_bits cleared", 32'(ctl_bits), 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule